// File: doc/BRIEF.md
# Zero-Extending Word Load Unit

This unit takes one 32-bit instruction word at a time and carries out any of four loads that bring a 32-bit word into a 64-bit general register. The high half of that register is cleared. The four loads are: displacement, displacement with base update, indexed, and indexed with base update. The unit reads its base and index operands through two read ports on an external 32-entry register file. It forms the effective address (EA) and fetches the word from a big-endian, byte-addressed memory through a 32-bit, word-aligned request port with a valid/ready handshake. It then writes the results back through a single register-file write port.

A word that crosses an aligned boundary does not fault. The unit fetches the two aligned words that hold it and assembles the four bytes in big-endian order. The update forms write the EA back into the base register one cycle after the destination write. The unit flags an update form whose encoding is illegal and drops it. An opcode outside the family is reported as not handled and has no other effect.

The controller is a state machine with these states:

| State | Meaning |
|-------|---------|
| `S_IDLE` | Waiting for an instruction. |
| `S_REQ0` | Issuing the first memory beat. |
| `S_RSP0` | Awaiting the first beat's data. |
| `S_REQ1` | Issuing the second beat. |
| `S_RSP1` | Awaiting the second beat's data. |
| `S_WR_DST` | Writing the destination register. |
| `S_WR_BASE` | Writing the base register. |

The transitions are:

| From | To | Condition |
|------|----|-----------|
| `S_IDLE` | `S_REQ0` | A legal load is accepted. |
| `S_REQ0` | `S_RSP0` | The request handshake completes. |
| `S_RSP0` | `S_REQ1` | The data arrives and the EA is misaligned. |
| `S_RSP0` | `S_WR_DST` | The data arrives and the EA is aligned. |
| `S_REQ1` | `S_RSP1` | The request handshake completes. |
| `S_RSP1` | `S_WR_DST` | The data arrives. |
| `S_WR_DST` | `S_WR_BASE` | The load is an update form. |
| `S_WR_DST` | `S_IDLE` | The load is not an update form. |
| `S_WR_BASE` | `S_IDLE` | Always. |

An unknown opcode or an illegal form keeps the unit in `S_IDLE`.

Top module: `wload_unit`

## Requirements
- R1: Instruction bit 0 is the most significant bit. Bits 0-5 hold the primary opcode. Bits 6-10 hold the destination register, 11-15 the base register, and 16-31 the displacement. Bits 16-20 hold the index register, 21-30 the extended opcode and 31 the record flag. Primary 32 decodes as the displacement load and 33 as the displacement load with update. Primary 31 with extended opcode 23 is the indexed load, and with 55 the indexed load with update.
- R2: In the two forms without update, a base field of 0 supplies the value zero, whatever register 0 holds.
- R3: The EA is the low 32 bits of the 64-bit sum of the base and an addend. The addend is the sign-extended displacement, or the whole 64-bit index register for the indexed forms.
- R4: The destination receives the four bytes at EA..EA+3 in the low 32 bits, the byte at EA being the most significant, with bits 63:32 cleared.
- R5: Every memory request address is word aligned. An EA with bits 1:0 equal to 0 takes exactly one beat. Any other EA takes two beats: first the word holding EA, then the next word, the address wrapping at 32 bits.
- R6: An update form writes the destination first and the base register with the zero-extended EA on the very next cycle.
- R7: An update form whose base field is 0, or equals the destination field, raises `illegal_form` during its offer cycle. It performs no memory request and no register write.
- R8: Any opcode outside the four raises `not_handled` during its offer cycle. It performs no memory request and no register write.
- R9: `in_ready` is high only in `S_IDLE`. It stays low from acceptance until the final register write is done.
- R10: A memory request, once raised, keeps its valid and address unchanged until `mem_req_ready` is seen.
- R11: After reset the unit is idle: `in_ready` is 1, and `mem_req_valid` and `wr_en` are 0.
- R12: The record flag (bit 31) does not change the behaviour of the indexed loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. |
| rst_n | input | 1 | Active-low asynchronous reset. |
| in_valid | input | 1 | Instruction offered. |
| in_insn | input | 32 | Instruction word. |
| in_ready | output | 1 | Unit idle; the offered instruction is taken this cycle. |
| rd_a_idx | output | 5 | Register-file read port A index (base field). |
| rd_a_data | input | 64 | Read port A data, combinational. |
| rd_b_idx | output | 5 | Read port B index (index field). |
| rd_b_data | input | 64 | Read port B data, combinational. |
| mem_req_valid | output | 1 | Memory read request valid. |
| mem_req_ready | input | 1 | Memory accepts the request. |
| mem_req_addr | output | 32 | Word-aligned request byte address. |
| mem_rsp_valid | input | 1 | Read data valid. |
| mem_rsp_data | input | 32 | Read data; byte at the lowest address in bits 31:24. |
| wr_en | output | 1 | Register write strobe. |
| wr_idx | output | 5 | Register write index. |
| wr_data | output | 64 | Register write data. |
| illegal_form | output | 1 | Offered update form is illegal. |
| not_handled | output | 1 | Offered opcode is outside the family. |

## Verification
The assertions assume the following of the memory side:
- Response data arrives only while a beat is outstanding.
- `mem_req_ready` may stall arbitrarily.
- The register file answers reads in the same cycle.

The bench's memory model holds `mem_req_ready` low on every third cycle so that stalled requests occur. It answers each accepted beat exactly once, on the following cycle. The bench offers instructions only on falling edges and withdraws them after one cycle. It never presents a response while the unit is not waiting for one.

// File: rtl/wl_pkg.sv
package wl_pkg;
    localparam int REG_W = 5;
    localparam int INSN_W = 32;

    localparam logic [5:0] OP_XFORM = 6'd31;
    localparam logic [5:0] OP_DISP = 6'd32;
    localparam logic [5:0] OP_DISP_UPD = 6'd33;
    localparam logic [9:0] XO_IDX = 10'd23;
    localparam logic [9:0] XO_IDX_UPD = 10'd55;

    typedef enum logic [2:0] {
        K_NONE,
        K_DISP,
        K_DISP_UPD,
        K_IDX,
        K_IDX_UPD
    } load_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ0,
        S_RSP0,
        S_REQ1,
        S_RSP1,
        S_WR_DST,
        S_WR_BASE
    } ctl_state_e;

    typedef struct packed {
        load_kind_e kind;
        logic update;
        logic indexed;
        logic zero_base;
        logic bad_form;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] index;
        logic [15:0] disp;
    } dec_t;
endpackage

// File: rtl/wl_decode.sv
module wl_decode
    import wl_pkg::*;
(
    input logic [INSN_W-1:0] insn,
    output dec_t dec
);
    logic [5:0] primary;
    logic [9:0] ext;

    // Big-endian bit i sits at vector position 31-i.
    assign primary = insn[31:26];
    assign ext = insn[10:1];

    always_comb begin
        dec = '0;
        dec.dst = insn[25:21];
        dec.base = insn[20:16];
        dec.index = insn[15:11];
        dec.disp = insn[15:0];
        unique case (primary)
            OP_DISP: dec.kind = K_DISP;
            OP_DISP_UPD: dec.kind = K_DISP_UPD;
            OP_XFORM: begin
                if (ext == XO_IDX) dec.kind = K_IDX;
                else if (ext == XO_IDX_UPD) dec.kind = K_IDX_UPD;
                else dec.kind = K_NONE;
            end
            default: dec.kind = K_NONE;
        endcase
        dec.update = (dec.kind == K_DISP_UPD) || (dec.kind == K_IDX_UPD);
        dec.indexed = (dec.kind == K_IDX) || (dec.kind == K_IDX_UPD);
        dec.zero_base = !dec.update && (dec.base == '0);
        dec.bad_form = dec.update && ((dec.base == '0) || (dec.base == dec.dst));
    end
endmodule

// File: rtl/wl_agen.sv
module wl_agen #(
    parameter int XLEN = 64,
    parameter int EA_W = 32
) (
    input logic zero_base,
    input logic indexed,
    input logic [XLEN-1:0] base_val,
    input logic [XLEN-1:0] index_val,
    input logic [15:0] disp,
    output logic [EA_W-1:0] ea
);
    logic [XLEN-1:0] base_eff;
    logic [XLEN-1:0] addend;
    logic [XLEN-1:0] sum;

    always_comb begin
        base_eff = zero_base ? '0 : base_val;
        addend = indexed ? index_val : {{(XLEN-16){disp[15]}}, disp};
        sum = base_eff + addend;
        ea = sum[EA_W-1:0];
    end
endmodule

// File: rtl/wl_merge.sv
module wl_merge #(
    parameter int MEM_W = 32,
    localparam int OFF_W = $clog2(MEM_W / 8)
) (
    input logic [MEM_W-1:0] beat_lo,
    input logic [MEM_W-1:0] beat_hi,
    input logic [OFF_W-1:0] offset,
    output logic [MEM_W-1:0] word
);
    logic [2*MEM_W-1:0] pair;
    logic [2*MEM_W-1:0] shifted;

    // The earlier beat holds the lower addresses, so it sits on top.
    always_comb begin
        pair = {beat_lo, beat_hi};
        shifted = pair << (8 * offset);
        word = shifted[2*MEM_W-1 -: MEM_W];
    end
endmodule

// File: rtl/wload_unit.sv
module wload_unit
    import wl_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int EA_W = 32,
    parameter int MEM_W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic [INSN_W-1:0] in_insn,
    output logic in_ready,
    output logic [REG_W-1:0] rd_a_idx,
    input logic [XLEN-1:0] rd_a_data,
    output logic [REG_W-1:0] rd_b_idx,
    input logic [XLEN-1:0] rd_b_data,
    output logic mem_req_valid,
    input logic mem_req_ready,
    output logic [EA_W-1:0] mem_req_addr,
    input logic mem_rsp_valid,
    input logic [MEM_W-1:0] mem_rsp_data,
    output logic wr_en,
    output logic [REG_W-1:0] wr_idx,
    output logic [XLEN-1:0] wr_data,
    output logic illegal_form,
    output logic not_handled
);
    localparam int NBYTE = MEM_W / 8;
    localparam int OFF_W = $clog2(NBYTE);

    ctl_state_e state, state_nx;
    dec_t dec;
    logic [EA_W-1:0] ea_comb;
    logic [EA_W-1:0] ea_q;
    logic [REG_W-1:0] dst_q;
    logic [REG_W-1:0] base_q;
    logic upd_q;
    logic [MEM_W-1:0] beat0_q;
    logic [MEM_W-1:0] beat1_q;
    logic [MEM_W-1:0] word;
    logic [EA_W-1:0] word_addr;
    logic misaligned;
    logic accept;

    wl_decode u_dec (
        .insn(in_insn),
        .dec(dec)
    );

    wl_agen #(
        .XLEN(XLEN),
        .EA_W(EA_W)
    ) u_agen (
        .zero_base(dec.zero_base),
        .indexed(dec.indexed),
        .base_val(rd_a_data),
        .index_val(rd_b_data),
        .disp(dec.disp),
        .ea(ea_comb)
    );

    wl_merge #(
        .MEM_W(MEM_W)
    ) u_merge (
        .beat_lo(beat0_q),
        .beat_hi(beat1_q),
        .offset(ea_q[OFF_W-1:0]),
        .word(word)
    );

    assign rd_a_idx = dec.base;
    assign rd_b_idx = dec.index;
    assign accept = (state == S_IDLE) && in_valid && (dec.kind != K_NONE) && !dec.bad_form;
    assign word_addr = {ea_q[EA_W-1:OFF_W], {OFF_W{1'b0}}};
    assign misaligned = (ea_q[OFF_W-1:0] != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = S_REQ0;
            S_REQ0: if (mem_req_ready) state_nx = S_RSP0;
            S_RSP0: if (mem_rsp_valid) state_nx = misaligned ? S_REQ1 : S_WR_DST;
            S_REQ1: if (mem_req_ready) state_nx = S_RSP1;
            S_RSP1: if (mem_rsp_valid) state_nx = S_WR_DST;
            S_WR_DST: state_nx = upd_q ? S_WR_BASE : S_IDLE;
            S_WR_BASE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Datapath captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q <= '0;
            dst_q <= '0;
            base_q <= '0;
            upd_q <= 1'b0;
            beat0_q <= '0;
            beat1_q <= '0;
        end else begin
            if (accept) begin
                ea_q <= ea_comb;
                dst_q <= dec.dst;
                base_q <= dec.base;
                upd_q <= dec.update;
                beat1_q <= '0;
            end
            if (state == S_RSP0 && mem_rsp_valid) beat0_q <= mem_rsp_data;
            if (state == S_RSP1 && mem_rsp_valid) beat1_q <= mem_rsp_data;
        end
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        illegal_form = 1'b0;
        not_handled = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr = word_addr;
        wr_en = 1'b0;
        wr_idx = dst_q;
        wr_data = {{(XLEN-MEM_W){1'b0}}, word};
        unique case (state)
            S_IDLE: begin
                in_ready = 1'b1;
                not_handled = in_valid && (dec.kind == K_NONE);
                illegal_form = in_valid && (dec.kind != K_NONE) && dec.bad_form;
            end
            S_REQ0: mem_req_valid = 1'b1;
            S_REQ1: begin
                mem_req_valid = 1'b1;
                mem_req_addr = word_addr + EA_W'(NBYTE);
            end
            S_WR_DST: wr_en = 1'b1;
            S_WR_BASE: begin
                wr_en = 1'b1;
                wr_idx = base_q;
                wr_data = {{(XLEN-EA_W){1'b0}}, ea_q};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wload_unit_chk.sv
module wload_unit_chk #(
    parameter int XLEN = 64,
    parameter int EA_W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic mem_req_valid,
    input logic mem_req_ready,
    input logic [EA_W-1:0] mem_req_addr,
    input logic wr_en,
    input logic [4:0] wr_idx,
    input logic [XLEN-1:0] wr_data,
    input logic illegal_form,
    input logic not_handled
);
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    a_r5_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    a_r9_busy_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !in_ready);

    a_r9_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !in_ready);

    a_r4_high_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_data[XLEN-1:EA_W] == '0);

    a_r6_second_write_other_reg: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_idx != $past(wr_idx));

    a_r6_at_most_two_writes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |=> !wr_en);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal_form && not_handled));

    a_r7_flag_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_form || not_handled) |-> in_ready && in_valid && !mem_req_valid && !wr_en);

    a_r8_no_start_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_form || not_handled) |=> in_ready);
endmodule

bind wload_unit wload_unit_chk #(
    .XLEN(XLEN),
    .EA_W(EA_W)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .wr_en(wr_en),
    .wr_idx(wr_idx),
    .wr_data(wr_data),
    .illegal_form(illegal_form),
    .not_handled(not_handled)
);

// File: tb/wload_unit_tb.sv
module wload_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic in_ready;
    logic [4:0] rd_a_idx;
    logic [4:0] rd_b_idx;
    logic [63:0] rd_a_data;
    logic [63:0] rd_b_data;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic wr_en;
    logic [4:0] wr_idx;
    logic [63:0] wr_data;
    logic illegal_form;
    logic not_handled;

    int checks = 0;
    int errors = 0;
    int beat_cnt = 0;
    int cyc = 0;
    logic done = 1'b0;
    logic [63:0] rf [32];

    always #2.5 clk = ~clk;

    assign rd_a_data = rf[rd_a_idx];
    assign rd_b_data = rf[rd_b_idx];

    wload_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_insn(in_insn), .in_ready(in_ready),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .illegal_form(illegal_form), .not_handled(not_handled)
    );

    function automatic logic [7:0] mb(input logic [31:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {mb(a), mb(a + 32'd1), mb(a + 32'd2), mb(a + 32'd3)};
    endfunction

    // Memory model: answers each accepted beat on the next cycle, stalls every third cycle.
    initial begin
        logic pend;
        logic [31:0] pend_addr;
        pend = 1'b0;
        pend_addr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem_word(pend_addr);
                pend = 1'b0;
            end
            mem_req_ready = (cyc % 3) != 1;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                pend = 1'b1;
                pend_addr = mem_req_addr;
                beat_cnt++;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_insn(input logic [31:0] insn, output int nwr,
                            output logic [4:0] i0, output logic [63:0] d0,
                            output logic [4:0] i1, output logic [63:0] d1,
                            output int gap, output logic ill, output logic nh,
                            output int beats, output logic busy);
        int c0;
        nwr = 0; i0 = '0; d0 = '0; i1 = '0; d1 = '0; gap = 0; c0 = 0;
        @(negedge clk);
        beat_cnt = 0;
        in_insn = insn;
        in_valid = 1'b1;
        #1;
        ill = illegal_form;
        nh = not_handled;
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        busy = !in_ready;
        for (int k = 0; k < 200; k++) begin
            if (wr_en) begin
                if (nwr == 0) begin i0 = wr_idx; d0 = wr_data; c0 = k; end
                else begin i1 = wr_idx; d1 = wr_data; gap = k - c0; end
                rf[wr_idx] = wr_data;
                nwr++;
            end
            if (in_ready) break;
            @(negedge clk);
            #1;
        end
        beats = beat_cnt;
    endtask

    typedef struct packed {
        logic [31:0] insn;
        logic [63:0] base;
        logic [63:0] idx;
        logic [31:0] ea;
        logic [4:0] rt;
        logic [4:0] ra;
        logic [4:0] rb;
        logic upd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{32'h80640010, 64'h1000, 64'h0, 32'h00001010, 5'd3, 5'd4, 5'd0, 1'b0},
        '{32'h80A6FFFC, 64'h2002, 64'h0, 32'h00001FFE, 5'd5, 5'd6, 5'd31, 1'b0},
        '{32'h80E08000, 64'hDEADBEEF12345678, 64'h0, 32'hFFFF8000, 5'd7, 5'd0, 5'd16, 1'b0},
        '{32'h85090003, 64'h3000, 64'h0, 32'h00003003, 5'd8, 5'd9, 5'd0, 1'b1},
        '{32'h7D4B602E, 64'h0000000100000100, 64'h1, 32'h00000101, 5'd10, 5'd11, 5'd12, 1'b0},
        '{32'h7DA0702E, 64'h77, 64'h4444, 32'h00004444, 5'd13, 5'd0, 5'd14, 1'b0},
        '{32'h7DF0886E, 64'h5000, 64'hFFFFFFFFFFFFFFFE, 32'h00004FFE, 5'd15, 5'd16, 5'd17, 1'b1},
        '{32'h80220001, 64'hFFFFFFFE, 64'h0, 32'hFFFFFFFF, 5'd1, 5'd2, 5'd0, 1'b0},
        '{32'h7E53A02F, 64'h7000, 64'hC, 32'h0000700C, 5'd18, 5'd19, 5'd20, 1'b0},
        '{32'h86B6FFFE, 64'h6001, 64'h0, 32'h00005FFF, 5'd21, 5'd22, 5'd31, 1'b1}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nwr, gap, beats;
        logic [4:0] i0, i1;
        logic [63:0] d0, d1;
        logic ill, nh, busy;
        for (int r = 0; r < 32; r++) rf[r] = 64'hA5A5_0000_0000_0000 | 64'(r);
        repeat (3) @(negedge clk);
        #1;
        // R11: idle after reset
        chk(in_ready == 1'b1, "R11 in_ready", 64'(in_ready), 64'd1);
        chk(mem_req_valid == 1'b0, "R11 mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk(wr_en == 1'b0, "R11 wr_en", 64'(wr_en), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R11 in_ready after release", 64'(in_ready), 64'd1);

        for (int v = 0; v < NV; v++) begin
            logic [31:0] w;
            rf[VEC[v].ra] = VEC[v].base;
            if (VEC[v].rb != VEC[v].ra) rf[VEC[v].rb] = VEC[v].idx;
            run_insn(VEC[v].insn, nwr, i0, d0, i1, d1, gap, ill, nh, beats, busy);
            w = mem_word(VEC[v].ea);
            chk(!ill && !nh, "R1 legal load flagged", {62'd0, ill, nh}, 64'd0);
            chk(busy, "R9 ready low while busy", 64'(busy), 64'd1);
            chk(nwr == (VEC[v].upd ? 2 : 1), "R6 write count", 64'(nwr), VEC[v].upd ? 64'd2 : 64'd1);
            chk(i0 == VEC[v].rt, "R1 destination index", 64'(i0), 64'(VEC[v].rt));
            // R2 (vectors 2 and 5), R3 (vectors 4 and 6), R12 (vector 8) via data
            chk(d0 == {32'd0, w}, "R4 R2 R3 R12 loaded data", d0, {32'd0, w});
            chk(beats == ((VEC[v].ea[1:0] != 2'b00) ? 2 : 1), "R5 beat count",
                64'(beats), (VEC[v].ea[1:0] != 2'b00) ? 64'd2 : 64'd1);
            if (VEC[v].upd) begin
                chk(i1 == VEC[v].ra, "R6 base index", 64'(i1), 64'(VEC[v].ra));
                chk(d1 == {32'd0, VEC[v].ea}, "R6 base value", d1, {32'd0, VEC[v].ea});
                chk(gap == 1, "R6 consecutive writes", 64'(gap), 64'd1);
            end
        end

        // R7: illegal update forms
        run_insn(32'h84800000, nwr, i0, d0, i1, d1, gap, ill, nh, beats, busy);
        chk(ill && !nh, "R7 flag base zero", {62'd0, ill, nh}, 64'd2);
        chk(nwr == 0 && beats == 0, "R7 no effects base zero", 64'(nwr + beats), 64'd0);
        run_insn(32'h7CA5306E, nwr, i0, d0, i1, d1, gap, ill, nh, beats, busy);
        chk(ill && !nh, "R7 flag base equals dest", {62'd0, ill, nh}, 64'd2);
        chk(nwr == 0 && beats == 0, "R7 no effects base equals dest", 64'(nwr + beats), 64'd0);

        // R8: unknown opcodes
        run_insn(32'h38000000, nwr, i0, d0, i1, d1, gap, ill, nh, beats, busy);
        chk(nh && !ill, "R8 flag primary 14", {62'd0, ill, nh}, 64'd1);
        chk(nwr == 0 && beats == 0, "R8 no effects primary 14", 64'(nwr + beats), 64'd0);
        run_insn(32'h7C000030, nwr, i0, d0, i1, d1, gap, ill, nh, beats, busy);
        chk(nh && !ill, "R8 flag extended 24", {62'd0, ill, nh}, 64'd1);
        chk(nwr == 0 && beats == 0, "R8 no effects extended 24", 64'(nwr + beats), 64'd0);

        // R9 R10: load right after rejects still completes normally
        rf[4] = 64'h1000;
        run_insn(32'h80640010, nwr, i0, d0, i1, d1, gap, ill, nh, beats, busy);
        chk(nwr == 1 && d0 == {32'd0, mem_word(32'h1010)}, "R9 load after reject", d0,
            {32'd0, mem_word(32'h1010)});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule